// File: doc/BRIEF.md
# PC/104 Expansion Bus Target Responder

This block sits on the card side of an 8/16-bit ISA-style stacking expansion bus and answers for one I/O window and one 128 KB memory block. From the bus address and command strobes it works out the four open-collector response lines a target owns: the 16-bit I/O select, the 16-bit memory select, the zero-wait-state request and channel ready. It also drives the channel check line when the local back-end reports a fatal error. Each open-collector line is presented as an output enable: when the enable is 1 the pad pulls the wire low, and when it is 0 the wire is released to its pull-up.

The select lines are pure address decodes, each from its own address group. Channel ready is pulled low for a parameterised number of bus clock edges at the start of every access that hits the block, and for as long after that as the back-end keeps its ready input low. Zero-wait-state is offered only for memory accesses, only when ready is not being held, and never in a DMA cycle (address enable high). The bus reset input releases every line at once and clears all state.

Top module: `isa_target_responder`

## Requirements
- R1: With addrEnable low, io16Oe is 1 exactly when sysAddr lies in [IO_BASE, IO_BASE+IO_SIZE), whatever the state of ioRdN and ioWrN.
- R2: mem16Oe is 1 exactly when latchAddr equals MEM_BLOCK, whatever the command strobes and addrEnable.
- R3: An access is an I/O strobe (ioRdN or ioWrN low) with addrEnable low and an I/O window hit, or a memory strobe (memRdN or memWrN low) with a memory block hit. chanRdyOe is 1 from the moment an access begins until WAIT_STATES rising clock edges have passed with the access still active, then 0.
- R4: While an access is active and localReady is low, chanRdyOe is 1 even after the wait-state count has expired.
- R5: zeroWsOe is 1 exactly when a memory strobe is active, latchAddr hits the memory block, addrEnable is low and chanRdyOe is 0.
- R6: zeroWsOe and chanRdyOe are never 1 together.
- R7: When localFatal is 1 at a rising clock edge, chanChkOe is 1 from that edge on and stays 1 until resetDrv.
- R8: While resetDrv is 1 all five output enables are 0 at once; the wait counter and the error latch are cleared, so the first access after reset gets the full wait count and chanChkOe stays 0.
- R9: With no access active (no strobe, or a strobe that misses), chanRdyOe and zeroWsOe are 0.
- R10: With addrEnable high, io16Oe and zeroWsOe are 0 and I/O strobes start no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| resetDrv | input | 1 | Bus reset, active high, asynchronous |
| sysAddr | input | 16 | Unlatched system address, low 16 bits |
| latchAddr | input | 7 | Latched address bits 23..17 |
| addrEnable | input | 1 | Address enable, high during DMA cycles |
| ioRdN | input | 1 | I/O read strobe, active low |
| ioWrN | input | 1 | I/O write strobe, active low |
| memRdN | input | 1 | Memory read strobe, active low |
| memWrN | input | 1 | Memory write strobe, active low |
| localReady | input | 1 | Back-end ready; low stretches the cycle |
| localFatal | input | 1 | Back-end fatal error report |
| io16Oe | output | 1 | Pull 16-bit I/O select low |
| mem16Oe | output | 1 | Pull 16-bit memory select low |
| zeroWsOe | output | 1 | Pull zero-wait-state low |
| chanRdyOe | output | 1 | Pull channel ready low |
| chanChkOe | output | 1 | Pull channel check low |

## Verification
The bench goes after the window edges one below the I/O base and one past its top, where a wrong mask would claim a neighbour's port or drop its own last one, and after address hits with no strobe, where a select gated by the strobes would go silent. It times ready edge by edge from the strobe, so an off-by-one counter shows up as one cycle too few or too many, and it holds back-end ready low to catch a design that lets zero-wait-state through while ready is held. DMA cycles with hitting addresses catch a design that answers I/O or offers early termination when it must not, and reset pulses in the middle of accesses and after an error catch a sticky check line or a counter that survives reset.

// File: rtl/isa_resp_pkg.sv
package isa_resp_pkg;

  // Strobes from the control module into the datapath.
  typedef struct packed {
    logic loadCnt;  // first cycle of an access: load the wait count
    logic decCnt;   // access continues and count not yet spent
    logic clrCnt;   // no access: park the counter at zero
    logic setErr;   // back-end reported a fatal error
  } ctrlStrobes_t;

  // Decode results from the datapath back to the control module.
  typedef struct packed {
    logic ioHit;
    logic memHit;
    logic cntZero;
    logic errFlag;
  } dpStatus_t;

endpackage

// File: rtl/isa_resp_datapath.sv
module isa_resp_datapath
  import isa_resp_pkg::*;
#(
  parameter logic [15:0] IO_BASE     = 16'h0300,
  parameter int          IO_SIZE     = 16,
  parameter logic [6:0]  MEM_BLOCK   = 7'h06,
  parameter int          WAIT_STATES = 3
) (
  input  logic         clk,
  input  logic         resetDrv,
  input  logic [15:0]  sysAddr,
  input  logic [6:0]   latchAddr,
  input  ctrlStrobes_t strobes,
  output dpStatus_t    status
);

  localparam int          CNT_W    = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);
  localparam logic [15:0] IO_MASK  = ~16'(IO_SIZE - 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = (WAIT_STATES == 0) ? '0 : CNT_W'(WAIT_STATES - 1);

  logic [CNT_W-1:0] waitCnt;
  logic             errLatch;
  logic             ioMatch;
  logic             memMatch;

  // Address compares: I/O window on the unlatched low address, memory
  // block on the latched high address, no strobe qualification here.
  always_comb begin
    ioMatch  = ((sysAddr & IO_MASK) == (IO_BASE & IO_MASK));
    memMatch = (latchAddr == MEM_BLOCK);
  end

  // Wait counter: clear has priority, then load, then count down.
  always_ff @(posedge clk or posedge resetDrv) begin
    if (resetDrv) begin
      waitCnt <= '0;
    end else if (strobes.clrCnt) begin
      waitCnt <= '0;
    end else if (strobes.loadCnt) begin
      waitCnt <= LOAD_VAL;
    end else if (strobes.decCnt && (waitCnt != '0)) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  // Sticky error flag, only bus reset clears it.
  always_ff @(posedge clk or posedge resetDrv) begin
    if (resetDrv) begin
      errLatch <= 1'b0;
    end else if (strobes.setErr) begin
      errLatch <= 1'b1;
    end
  end

  always_comb begin
    status.ioHit   = ioMatch;
    status.memHit  = memMatch;
    status.cntZero = (waitCnt == '0);
    status.errFlag = errLatch;
  end

endmodule

// File: rtl/isa_resp_ctrl.sv
module isa_resp_ctrl
  import isa_resp_pkg::*;
#(
  parameter int WAIT_STATES = 3
) (
  input  logic         clk,
  input  logic         resetDrv,
  input  logic         addrEnable,
  input  logic         ioRdN,
  input  logic         ioWrN,
  input  logic         memRdN,
  input  logic         memWrN,
  input  logic         localReady,
  input  logic         localFatal,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         io16Oe,
  output logic         mem16Oe,
  output logic         zeroWsOe,
  output logic         chanRdyOe,
  output logic         chanChkOe
);

  localparam logic START_HOLD = (WAIT_STATES != 0);

  logic accPrev;
  logic ioStrobe;
  logic memStrobe;
  logic ioAccess;
  logic memAccess;
  logic accActive;
  logic accStart;
  logic rdyHold;

  always_comb begin
    ioStrobe  = !ioRdN || !ioWrN;
    memStrobe = !memRdN || !memWrN;
    // A DMA cycle (address enable high) never starts an I/O access.
    ioAccess  = !addrEnable && status.ioHit && ioStrobe;
    memAccess = status.memHit && memStrobe;
    accActive = ioAccess || memAccess;
    accStart  = accActive && !accPrev;
  end

  // Remember whether an access was under way at the last edge.
  always_ff @(posedge clk or posedge resetDrv) begin
    if (resetDrv) begin
      accPrev <= 1'b0;
    end else begin
      accPrev <= accActive;
    end
  end

  // Ready is held on the first cycle (the counter is not loaded yet),
  // then while the counter runs, and whenever the back-end is not ready.
  always_comb begin
    rdyHold = accActive && ((accStart ? START_HOLD : !status.cntZero) || !localReady);
  end

  always_comb begin
    strobes.loadCnt = accStart;
    strobes.decCnt  = accActive && !accStart && !status.cntZero;
    strobes.clrCnt  = !accActive;
    strobes.setErr  = localFatal;
  end

  // Open-collector enables; bus reset releases every one of them.
  always_comb begin
    io16Oe    = !resetDrv && !addrEnable && status.ioHit;
    mem16Oe   = !resetDrv && status.memHit;
    chanRdyOe = !resetDrv && rdyHold;
    // Early termination only for memory cycles, never in DMA, never
    // while ready is being held.
    zeroWsOe  = !resetDrv && !addrEnable && memAccess && !rdyHold;
    chanChkOe = !resetDrv && status.errFlag;
  end

endmodule

// File: rtl/isa_target_responder.sv
module isa_target_responder
  import isa_resp_pkg::*;
#(
  parameter logic [15:0] IO_BASE     = 16'h0300,
  parameter int          IO_SIZE     = 16,
  parameter logic [6:0]  MEM_BLOCK   = 7'h06,
  parameter int          WAIT_STATES = 3
) (
  input  logic        clk,
  input  logic        resetDrv,
  input  logic [15:0] sysAddr,
  input  logic [6:0]  latchAddr,
  input  logic        addrEnable,
  input  logic        ioRdN,
  input  logic        ioWrN,
  input  logic        memRdN,
  input  logic        memWrN,
  input  logic        localReady,
  input  logic        localFatal,
  output logic        io16Oe,
  output logic        mem16Oe,
  output logic        zeroWsOe,
  output logic        chanRdyOe,
  output logic        chanChkOe
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  isa_resp_datapath #(
    .IO_BASE    (IO_BASE),
    .IO_SIZE    (IO_SIZE),
    .MEM_BLOCK  (MEM_BLOCK),
    .WAIT_STATES(WAIT_STATES)
  ) i_datapath (
    .clk      (clk),
    .resetDrv (resetDrv),
    .sysAddr  (sysAddr),
    .latchAddr(latchAddr),
    .strobes  (strobes),
    .status   (status)
  );

  isa_resp_ctrl #(
    .WAIT_STATES(WAIT_STATES)
  ) i_ctrl (
    .clk       (clk),
    .resetDrv  (resetDrv),
    .addrEnable(addrEnable),
    .ioRdN     (ioRdN),
    .ioWrN     (ioWrN),
    .memRdN    (memRdN),
    .memWrN    (memWrN),
    .localReady(localReady),
    .localFatal(localFatal),
    .status    (status),
    .strobes   (strobes),
    .io16Oe    (io16Oe),
    .mem16Oe   (mem16Oe),
    .zeroWsOe  (zeroWsOe),
    .chanRdyOe (chanRdyOe),
    .chanChkOe (chanChkOe)
  );

endmodule

// File: rtl/isa_resp_checker.sv
module isa_resp_checker (
  input logic clk,
  input logic resetDrv,
  input logic addrEnable,
  input logic ioRdN,
  input logic ioWrN,
  input logic memRdN,
  input logic memWrN,
  input logic localFatal,
  input logic io16Oe,
  input logic mem16Oe,
  input logic zeroWsOe,
  input logic chanRdyOe,
  input logic chanChkOe
);

  // R10 / R1: no 16-bit I/O select during a DMA cycle.
  assert_io16_dma_R10: assert property (@(posedge clk) disable iff (resetDrv)
    addrEnable |-> !io16Oe);

  // R5: early termination only with a memory strobe outside DMA.
  assert_zws_strobe_R5: assert property (@(posedge clk) disable iff (resetDrv)
    zeroWsOe |-> ((!memRdN || !memWrN) && !addrEnable));

  // R6: ready wins over early termination.
  assert_rdy_over_zws_R6: assert property (@(posedge clk) disable iff (resetDrv)
    !(zeroWsOe && chanRdyOe));

  // R7: a reported fatal error shows on channel check after the edge.
  assert_fatal_reported_R7: assert property (@(posedge clk) disable iff (resetDrv)
    localFatal |=> chanChkOe);

  // R7: channel check is sticky until bus reset.
  assert_chk_sticky_R7: assert property (@(posedge clk) disable iff (resetDrv)
    chanChkOe |=> chanChkOe);

  // R8: everything released while bus reset is high.
  assert_reset_release_R8: assert property (@(posedge clk)
    resetDrv |-> !(io16Oe || mem16Oe || zeroWsOe || chanRdyOe || chanChkOe));

  // R9: with no strobe at all, neither ready nor early termination.
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (resetDrv)
    (ioRdN && ioWrN && memRdN && memWrN) |-> (!chanRdyOe && !zeroWsOe));

endmodule

bind isa_target_responder isa_resp_checker i_resp_checker (
  .clk       (clk),
  .resetDrv  (resetDrv),
  .addrEnable(addrEnable),
  .ioRdN     (ioRdN),
  .ioWrN     (ioWrN),
  .memRdN    (memRdN),
  .memWrN    (memWrN),
  .localFatal(localFatal),
  .io16Oe    (io16Oe),
  .mem16Oe   (mem16Oe),
  .zeroWsOe  (zeroWsOe),
  .chanRdyOe (chanRdyOe),
  .chanChkOe (chanChkOe)
);

// File: tb/test_isa_target_responder.sv
module test_isa_target_responder;

  localparam logic [15:0] IO_BASE     = 16'h0300;
  localparam int          IO_SIZE     = 16;
  localparam logic [6:0]  MEM_BLOCK   = 7'h06;
  localparam int          WAIT_STATES = 3;

  logic        clk = 1'b0;
  logic        resetDrv;
  logic [15:0] sysAddr;
  logic [6:0]  latchAddr;
  logic        addrEnable;
  logic        ioRdN, ioWrN, memRdN, memWrN;
  logic        localReady, localFatal;
  logic        io16Oe, mem16Oe, zeroWsOe, chanRdyOe, chanChkOe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model state: edges an access has been active, sticky error.
  int edgesIn = 0;
  bit errModel = 1'b0;

  always #10 clk = ~clk;

  isa_target_responder #(
    .IO_BASE(IO_BASE), .IO_SIZE(IO_SIZE),
    .MEM_BLOCK(MEM_BLOCK), .WAIT_STATES(WAIT_STATES)
  ) i_isa_target_responder (
    .clk(clk), .resetDrv(resetDrv), .sysAddr(sysAddr), .latchAddr(latchAddr),
    .addrEnable(addrEnable), .ioRdN(ioRdN), .ioWrN(ioWrN), .memRdN(memRdN),
    .memWrN(memWrN), .localReady(localReady), .localFatal(localFatal),
    .io16Oe(io16Oe), .mem16Oe(mem16Oe), .zeroWsOe(zeroWsOe),
    .chanRdyOe(chanRdyOe), .chanChkOe(chanChkOe)
  );

  function automatic bit ioHitF();
    return (sysAddr >= IO_BASE) && (32'(sysAddr) < 32'(IO_BASE) + IO_SIZE);
  endfunction

  function automatic bit memHitF();
    return latchAddr == MEM_BLOCK;
  endfunction

  function automatic bit memStrF();
    return !memRdN || !memWrN;
  endfunction

  function automatic bit accessF();
    return (!addrEnable && ioHitF() && (!ioRdN || !ioWrN)) || (memHitF() && memStrF());
  endfunction

  always @(posedge clk) begin
    if (resetDrv) begin
      edgesIn  <= 0;
      errModel <= 1'b0;
    end else begin
      edgesIn <= accessF() ? ((edgesIn < 1000) ? edgesIn + 1 : edgesIn) : 0;
      if (localFatal) errModel <= 1'b1;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    bit expRdy;
    if (resetDrv) begin
      check("R8", "io16Oe", io16Oe, 1'b0);
      check("R8", "mem16Oe", mem16Oe, 1'b0);
      check("R8", "zeroWsOe", zeroWsOe, 1'b0);
      check("R8", "chanRdyOe", chanRdyOe, 1'b0);
      check("R8", "chanChkOe", chanChkOe, 1'b0);
    end else begin
      expRdy = accessF() && ((edgesIn < WAIT_STATES) || !localReady);
      check(addrEnable ? "R10" : "R1", "io16Oe", io16Oe, ioHitF() && !addrEnable);
      check("R2", "mem16Oe", mem16Oe, memHitF());
      check(!accessF() ? "R9" : (!localReady ? "R4" : "R3"), "chanRdyOe", chanRdyOe, expRdy);
      check(addrEnable ? "R10" : "R5", "zeroWsOe", zeroWsOe,
            memHitF() && memStrF() && !addrEnable && !expRdy);
      check("R6", "zws with ready", zeroWsOe && chanRdyOe, 1'b0);
      check("R7", "chanChkOe", chanChkOe, errModel);
    end
  endtask

  task automatic idle();
    ioRdN = 1'b1; ioWrN = 1'b1; memRdN = 1'b1; memWrN = 1'b1;
    addrEnable = 1'b0; localReady = 1'b1; localFatal = 1'b0;
  endtask

  task automatic stepCheck();
    @(negedge clk);
    #2 checkAll();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    resetDrv = 1'b1; sysAddr = IO_BASE; latchAddr = MEM_BLOCK;
    idle();
    localFatal = 1'b1;             // must be ignored under reset (R8)
    repeat (3) @(negedge clk);
    #2 checkAll();                 // reset state, all released: R8
    @(negedge clk);
    resetDrv = 1'b0; localFatal = 1'b0;
    #2 check("R8", "chanChkOe after reset", chanChkOe, 1'b0);

    // R1: select from address alone, window boundaries
    @(negedge clk); sysAddr = IO_BASE + 16'd5; latchAddr = 7'h00; #2 checkAll();
    check("R1", "io16 without strobe", io16Oe, 1'b1);
    @(negedge clk); sysAddr = IO_BASE - 16'd1; #2 checkAll();
    @(negedge clk); sysAddr = IO_BASE + 16'(IO_SIZE); #2 checkAll();
    @(negedge clk); sysAddr = IO_BASE + 16'(IO_SIZE - 1); #2 checkAll();
    // R10: DMA cycle hides the I/O window even with a strobe
    @(negedge clk); addrEnable = 1'b1; ioRdN = 1'b0; #2 checkAll();
    check("R10", "io16 in dma", io16Oe, 1'b0);
    check("R10", "ready in dma io", chanRdyOe, 1'b0);
    @(negedge clk); idle(); #2 checkAll();

    // R3: ready timed edge by edge from the strobe
    @(negedge clk); sysAddr = IO_BASE; ioWrN = 1'b0; #2 checkAll();
    check("R3", "ready at strobe", chanRdyOe, WAIT_STATES != 0);
    for (int k = 1; k <= WAIT_STATES + 1; k++) begin
      stepCheck();
      check("R3", "ready after edges", chanRdyOe, k < WAIT_STATES);
    end
    @(negedge clk); idle(); #2 checkAll();

    // R4/R5: memory access, back-end holds ready, then early termination
    @(negedge clk); latchAddr = MEM_BLOCK; sysAddr = 16'h0000; memRdN = 1'b0; localReady = 1'b0;
    #2 checkAll();
    for (int k = 1; k <= WAIT_STATES + 2; k++) stepCheck();
    check("R4", "ready held by back-end", chanRdyOe, 1'b1);
    check("R5", "no zws while held", zeroWsOe, 1'b0);
    @(negedge clk); localReady = 1'b1; #2 checkAll();
    check("R5", "zws after release", zeroWsOe, 1'b1);
    @(negedge clk); addrEnable = 1'b1; #2 checkAll();
    check("R10", "zws in dma", zeroWsOe, 1'b0);
    @(negedge clk); idle(); #2 checkAll();

    // R7/R8: sticky check line, cleared only by reset
    @(negedge clk); localFatal = 1'b1; #2 checkAll();
    @(negedge clk); localFatal = 1'b0; #2 checkAll();
    check("R7", "check asserted", chanChkOe, 1'b1);
    repeat (4) stepCheck();
    check("R7", "check still asserted", chanChkOe, 1'b1);
    @(negedge clk); resetDrv = 1'b1; #2 checkAll();
    @(negedge clk); resetDrv = 1'b0; #2 checkAll();
    check("R8", "check cleared by reset", chanChkOe, 1'b0);

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (resetDrv) resetDrv = 1'b0;
      else if ($urandom_range(199) == 0) resetDrv = 1'b1;
      localFatal = ($urandom_range(149) == 0);
      if ($urandom_range(2) == 0) begin
        case ($urandom_range(5))
          0, 1:    sysAddr = IO_BASE + 16'($urandom_range(IO_SIZE - 1));
          2:       sysAddr = IO_BASE - 16'd1;
          3:       sysAddr = IO_BASE + 16'(IO_SIZE);
          default: sysAddr = 16'($urandom);
        endcase
        latchAddr  = ($urandom_range(1) == 0) ? MEM_BLOCK : 7'($urandom);
        addrEnable = ($urandom_range(5) == 0);
        ioRdN  = ($urandom_range(3) != 0);
        ioWrN  = ($urandom_range(3) != 0);
        memRdN = ($urandom_range(3) != 0);
        memWrN = ($urandom_range(3) != 0);
      end
      if ($urandom_range(3) == 0) localReady = ($urandom_range(4) != 0);
      #2 checkAll();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule